// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This unit settles the outcome of a single branch instruction. It accepts a 32-bit instruction word with the current instruction address, the count register, the link register and the 32-bit condition register. One clock later it reports whether the branch is taken, the address of the next instruction, the new count register value and the new link register value. A pipeline front end or a single-step helper uses it to move the instruction address and the two special registers forward by one branch.

Three branch forms are handled. The first is a conditional form with a 14-bit word displacement. The second is an unconditional form with a 24-bit word displacement. The third is an indirect form whose target comes from the link or count register. In the conditional and indirect forms, a 5-bit option field chooses any mix of three actions: decrementing the counter, testing the counter for zero, and testing one condition bit. A mode input limits the produced addresses to 32 bits. Instruction words of any other kind fall through to the next sequential address and leave all registers unchanged.

Top module: `branch_resolve_unit`

## Requirements
- R1: While `rst` is high and on the cycle after it, `valid_o`, `taken_o`, `next_pc_o`, `ctr_o` and `lr_o` are all zero.
- R2: A word presented with `valid_i` high produces its results on the outputs one clock later, with `valid_o` high. While `valid_i` is low, `valid_o` is low and the other outputs keep their last values.
- R3: The option field is bits 25:21 and the condition index n is bits 20:16. If option bit 4 is 0, the branch needs condition register bit position 31−n to equal option bit 3. If option bit 4 is 1, the condition register has no effect.
- R4: If option bit 2 is 0, `ctr_o` is `ctr_i` − 1 (wrapping), and the branch needs (decremented counter == 0) to equal option bit 1. If option bit 2 is 1, `ctr_o` equals `ctr_i` and the counter is not tested.
- R5: Primary opcode 16 (bits 31:26) is the conditional form. Its offset is bits 15:2 followed by two zero bits, sign-extended from bit 15. If bit 1 is 0, the target is address + offset. If bit 1 is 1, the target is the offset itself.
- R6: Primary opcode 18 is the unconditional form. It is always taken and `ctr_o` equals `ctr_i`. Its offset is bits 25:2 followed by two zero bits, sign-extended from bit 25. The bit 1 rule of R5 applies.
- R7: Primary opcode 19 with bits 10:1 equal to 16 or 528 is the indirect form. If bit 10 is 1, the target is the incoming count register; otherwise it is the incoming link register. In both cases the two low target bits are cleared. The option rules of R3 and R4 apply.
- R8: If bit 0 of a branch word is 1, `lr_o` is address + 4, whether or not the branch is taken. This holds even when the target came from the old link register. If bit 0 is 0, `lr_o` equals `lr_i`.
- R9: A branch that is not taken gives `next_pc_o` = address + 4.
- R10: With `mode32_i` high, `next_pc_o` and a written `lr_o` keep only their low 32 bits. The counter stays full width, both in its value and in its zero test.
- R11: Any word that is not one of the three branch forms gives `taken_o` = 0 and `next_pc_o` = address + 4, and passes `ctr_i` and `lr_i` through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Instruction word and registers are valid this cycle |
| instr_i | input | 32 | Instruction word |
| pc_i | input | XLEN | Address of the instruction |
| ctr_i | input | XLEN | Incoming count register |
| lr_i | input | XLEN | Incoming link register |
| cr_i | input | 32 | Incoming condition register |
| mode32_i | input | 1 | Truncate produced addresses to 32 bits |
| valid_o | output | 1 | Results below belong to a word accepted last cycle |
| taken_o | output | 1 | Branch taken |
| next_pc_o | output | XLEN | Address of the next instruction |
| ctr_o | output | XLEN | Updated count register |
| lr_o | output | XLEN | Updated link register |

## Verification
A wrong condition-bit index or wrong option decoding shows up as a flipped `taken_o`. Because there is only one register stage, it also shows up as a next address differing by the offset on the very next cycle. A wrong decrement or zero test shows in `ctr_o` in the same cycle, and can also flip `taken_o` when the counter sits at one or zero. Since every output is registered once, each fault is visible exactly one clock after the offending word, and the bench samples each result in that cycle.

// File: rtl/bru_pkg.sv
package bru_pkg;

  typedef enum logic [1:0] {
    FORM_NONE,
    FORM_COND_IMM,
    FORM_UNCOND,
    FORM_INDIRECT
  } bform_e;

  localparam logic [5:0] OPC_COND_IMM = 6'd16;
  localparam logic [5:0] OPC_UNCOND   = 6'd18;
  localparam logic [5:0] OPC_EXT      = 6'd19;
  localparam logic [9:0] XO_VIA_LINK  = 10'd16;
  localparam logic [9:0] XO_VIA_COUNT = 10'd528;

  function automatic bform_e decode_form(input logic [31:0] word);
    bform_e f;
    f = FORM_NONE;
    unique case (word[31:26])
      OPC_COND_IMM: f = FORM_COND_IMM;
      OPC_UNCOND:   f = FORM_UNCOND;
      OPC_EXT: begin
        if (word[10:1] == XO_VIA_LINK || word[10:1] == XO_VIA_COUNT)
          f = FORM_INDIRECT;
      end
      default: f = FORM_NONE;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/bru_cond_eval.sv
module bru_cond_eval #(
  parameter int XLEN = 64
) (
  input  logic            use_opts_i,
  input  logic [31:0]     instr_i,
  input  logic [XLEN-1:0] ctr_i,
  input  logic [31:0]     cr_i,
  output logic            taken_o,
  output logic [XLEN-1:0] ctr_next_o
);
  logic [4:0]      opts;
  logic [4:0]      cidx;
  logic [4:0]      cpos;
  logic            cbit;
  logic [XLEN-1:0] ctr_dec;
  logic            cond_ok;
  logic            ctr_ok;

  assign opts    = instr_i[25:21];
  assign cidx    = instr_i[20:16];
  assign cpos    = 5'd31 - cidx;
  assign cbit    = cr_i[cpos];
  assign ctr_dec = ctr_i - XLEN'(1);

  always_comb begin
    cond_ok = opts[4] | (cbit == opts[3]);
    ctr_ok  = opts[2] | (opts[1] == (ctr_dec == '0));
    if (use_opts_i) begin
      taken_o    = cond_ok & ctr_ok;
      ctr_next_o = opts[2] ? ctr_i : ctr_dec;
    end else begin
      taken_o    = 1'b1;
      ctr_next_o = ctr_i;
    end
  end

endmodule

// File: rtl/bru_target_gen.sv
module bru_target_gen
  import bru_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  bform_e          form_i,
  input  logic [31:0]     instr_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] ctr_i,
  input  logic [XLEN-1:0] lr_i,
  input  logic            mode32_i,
  output logic [XLEN-1:0] target_o,
  output logic [XLEN-1:0] seq_pc_o
);
  localparam int SHORT_PAD = XLEN - 16;
  localparam int LONG_PAD  = XLEN - 26;

  logic [XLEN-1:0] keep_mask;
  logic [XLEN-1:0] off_short;
  logic [XLEN-1:0] off_long;
  logic [XLEN-1:0] raw_target;
  logic [XLEN-1:0] raw_seq;

  generate
    if (XLEN > 32) begin : g_wide
      assign keep_mask = mode32_i ? {{(XLEN-32){1'b0}}, {32{1'b1}}} : {XLEN{1'b1}};
    end else begin : g_narrow
      assign keep_mask = {XLEN{1'b1}};
    end
  endgenerate

  assign off_short = {{SHORT_PAD{instr_i[15]}}, instr_i[15:2], 2'b00};
  assign off_long  = {{LONG_PAD{instr_i[25]}}, instr_i[25:2], 2'b00};
  assign raw_seq   = pc_i + XLEN'(4);

  always_comb begin
    unique case (form_i)
      FORM_COND_IMM: raw_target = instr_i[1] ? off_short : pc_i + off_short;
      FORM_UNCOND:   raw_target = instr_i[1] ? off_long  : pc_i + off_long;
      FORM_INDIRECT: raw_target = (instr_i[10] ? ctr_i : lr_i) & ~XLEN'(3);
      default:       raw_target = raw_seq;
    endcase
  end

  assign target_o = raw_target & keep_mask;
  assign seq_pc_o = raw_seq & keep_mask;

endmodule

// File: rtl/branch_resolve_unit.sv
module branch_resolve_unit
  import bru_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            valid_i,
  input  logic [31:0]     instr_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] ctr_i,
  input  logic [XLEN-1:0] lr_i,
  input  logic [31:0]     cr_i,
  input  logic            mode32_i,
  output logic            valid_o,
  output logic            taken_o,
  output logic [XLEN-1:0] next_pc_o,
  output logic [XLEN-1:0] ctr_o,
  output logic [XLEN-1:0] lr_o
);
  bform_e          form;
  logic            use_opts;
  logic            eval_taken;
  logic [XLEN-1:0] eval_ctr;
  logic [XLEN-1:0] target;
  logic [XLEN-1:0] seq_pc;
  logic            is_branch;
  logic            br_taken;
  logic [XLEN-1:0] pc_d;
  logic [XLEN-1:0] ctr_d;
  logic [XLEN-1:0] lr_d;

  assign form      = decode_form(instr_i);
  assign is_branch = (form != FORM_NONE);
  assign use_opts  = (form == FORM_COND_IMM) || (form == FORM_INDIRECT);

  bru_cond_eval #(.XLEN(XLEN)) u_cond (
    .use_opts_i (use_opts),
    .instr_i    (instr_i),
    .ctr_i      (ctr_i),
    .cr_i       (cr_i),
    .taken_o    (eval_taken),
    .ctr_next_o (eval_ctr)
  );

  bru_target_gen #(.XLEN(XLEN)) u_tgt (
    .form_i   (form),
    .instr_i  (instr_i),
    .pc_i     (pc_i),
    .ctr_i    (ctr_i),
    .lr_i     (lr_i),
    .mode32_i (mode32_i),
    .target_o (target),
    .seq_pc_o (seq_pc)
  );

  assign br_taken = is_branch & eval_taken;
  assign pc_d     = br_taken ? target : seq_pc;
  assign ctr_d    = is_branch ? eval_ctr : ctr_i;
  assign lr_d     = (is_branch && instr_i[0]) ? seq_pc : lr_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o   <= 1'b0;
      taken_o   <= 1'b0;
      next_pc_o <= '0;
      ctr_o     <= '0;
      lr_o      <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        taken_o   <= br_taken;
        next_pc_o <= pc_d;
        ctr_o     <= ctr_d;
        lr_o      <= lr_d;
      end
    end
  end

  assert_valid_follow_R2: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> valid_o);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> (!valid_o && $stable(next_pc_o) && $stable(ctr_o) && $stable(lr_o)));

  assert_ctr_kept_R4: assert property (@(posedge clk) disable iff (rst)
    (valid_i && instr_i[23]) |=> ctr_o == $past(ctr_i));

  assert_uncond_taken_R6: assert property (@(posedge clk) disable iff (rst)
    (valid_i && instr_i[31:26] == OPC_UNCOND) |=> taken_o);

  assert_link_write_R8: assert property (@(posedge clk) disable iff (rst)
    (valid_i && is_branch && instr_i[0]) |=> lr_o[31:0] == $past(pc_i[31:0]) + 32'd4);

  assert_fallthrough_R9: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> (taken_o || next_pc_o[31:0] == $past(pc_i[31:0]) + 32'd4));

  assert_nonbranch_R11: assert property (@(posedge clk) disable iff (rst)
    (valid_i && !is_branch) |=> (!taken_o && ctr_o == $past(ctr_i) && lr_o == $past(lr_i)));

  generate
    if (XLEN > 32) begin : g_chk_wide
      assert_trunc_pc_R10: assert property (@(posedge clk) disable iff (rst)
        (valid_i && mode32_i) |=> next_pc_o[XLEN-1:32] == '0);
    end
  endgenerate

endmodule

// File: tb/branch_resolve_unit_tb.sv
module branch_resolve_unit_tb_top;
  localparam int  XLEN       = 64;
  localparam time CLK_PERIOD = 10ns;

  logic            clk = 1'b0;
  logic            rst;
  logic            valid_i;
  logic [31:0]     instr_i;
  logic [XLEN-1:0] pc_i, ctr_i, lr_i;
  logic [31:0]     cr_i;
  logic            mode32_i;
  logic            valid_o, taken_o;
  logic [XLEN-1:0] next_pc_o, ctr_o, lr_o;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_resolve_unit #(.XLEN(XLEN)) dut_i (
    .clk(clk), .rst(rst), .valid_i(valid_i), .instr_i(instr_i), .pc_i(pc_i),
    .ctr_i(ctr_i), .lr_i(lr_i), .cr_i(cr_i), .mode32_i(mode32_i),
    .valid_o(valid_o), .taken_o(taken_o), .next_pc_o(next_pc_o),
    .ctr_o(ctr_o), .lr_o(lr_o)
  );

  function automatic logic [31:0] enc_cond(logic [4:0] bo, logic [4:0] bi,
                                           logic [13:0] bd, logic aa, logic lk);
    return {6'd16, bo, bi, bd, aa, lk};
  endfunction

  function automatic logic [31:0] enc_long(logic [23:0] li, logic aa, logic lk);
    return {6'd18, li, aa, lk};
  endfunction

  function automatic logic [31:0] enc_ind(logic [4:0] bo, logic via_ctr, logic lk);
    return {6'd19, bo, 5'd0, 5'd0, (via_ctr ? 10'd528 : 10'd16), lk};
  endfunction

  task automatic chk(string req, string what, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_word(string req, logic [31:0] w, logic [XLEN-1:0] pc,
                          logic [XLEN-1:0] ctr, logic [XLEN-1:0] lr, logic [31:0] cr,
                          logic m32, logic e_taken, logic [XLEN-1:0] e_next,
                          logic [XLEN-1:0] e_ctr, logic [XLEN-1:0] e_lr);
    @(negedge clk);
    instr_i = w; pc_i = pc; ctr_i = ctr; lr_i = lr; cr_i = cr; mode32_i = m32;
    valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    chk(req, "valid_o", XLEN'(valid_o), XLEN'(1));
    chk(req, "taken_o", XLEN'(taken_o), XLEN'(e_taken));
    chk(req, "next_pc_o", next_pc_o, e_next);
    chk(req, "ctr_o", ctr_o, e_ctr);
    chk(req, "lr_o", lr_o, e_lr);
  endtask

  task automatic test_reset_R1();
    chk("R1", "valid_o", XLEN'(valid_o), '0);
    chk("R1", "taken_o", XLEN'(taken_o), '0);
    chk("R1", "next_pc_o", next_pc_o, '0);
    chk("R1", "ctr_o", ctr_o, '0);
    chk("R1", "lr_o", lr_o, '0);
  endtask

  task automatic test_cond_bit_R3();
    run_word("R3", enc_cond(5'b01100, 5'd2, 14'h10, 0, 0), 64'h1000, 64'd5, 64'hAAAA,
             32'h2000_0000, 0, 1, 64'h1040, 64'd5, 64'hAAAA);
    run_word("R3", enc_cond(5'b01100, 5'd2, 14'h10, 0, 0), 64'h1000, 64'd5, 64'hAAAA,
             32'h0, 0, 0, 64'h1004, 64'd5, 64'hAAAA);
    run_word("R3", enc_cond(5'b00100, 5'd2, 14'h10, 0, 0), 64'h1000, 64'd5, 64'hAAAA,
             32'h0, 0, 1, 64'h1040, 64'd5, 64'hAAAA);
    run_word("R3", enc_cond(5'b00100, 5'd2, 14'h10, 0, 0), 64'h1000, 64'd5, 64'hAAAA,
             32'h2000_0000, 0, 0, 64'h1004, 64'd5, 64'hAAAA);
    run_word("R3", enc_cond(5'b01100, 5'd31, 14'h10, 0, 0), 64'h1000, 64'd5, 64'hAAAA,
             32'h1, 0, 1, 64'h1040, 64'd5, 64'hAAAA);
    run_word("R3", enc_cond(5'b01100, 5'd0, 14'h10, 0, 0), 64'h1000, 64'd5, 64'hAAAA,
             32'h7FFF_FFFF, 0, 0, 64'h1004, 64'd5, 64'hAAAA);
  endtask

  task automatic test_counter_R4();
    run_word("R4", enc_cond(5'b10000, 5'd0, 14'h3FF0, 0, 0), 64'h2000, 64'd2, 64'h0,
             32'hFFFF_FFFF, 0, 1, 64'h1FC0, 64'd1, 64'h0);
    run_word("R4", enc_cond(5'b10000, 5'd0, 14'h3FF0, 0, 0), 64'h2000, 64'd1, 64'h0,
             32'h0, 0, 0, 64'h2004, 64'd0, 64'h0);
    run_word("R4", enc_cond(5'b10010, 5'd0, 14'h3FF0, 0, 0), 64'h2000, 64'd1, 64'h0,
             32'h0, 0, 1, 64'h1FC0, 64'd0, 64'h0);
    run_word("R4", enc_cond(5'b10000, 5'd0, 14'h3FF0, 0, 0), 64'h2000, 64'd0, 64'h0,
             32'h0, 0, 1, 64'h1FC0, {XLEN{1'b1}}, 64'h0);
  endtask

  task automatic test_absolute_R5();
    run_word("R5", enc_cond(5'b10100, 5'd0, 14'h0400, 1, 0), 64'h8000, 64'd3, 64'h0,
             32'h0, 0, 1, 64'h1000, 64'd3, 64'h0);
    run_word("R5", enc_cond(5'b10100, 5'd0, 14'h2000, 1, 0), 64'h8000, 64'd3, 64'h0,
             32'h0, 0, 1, 64'hFFFF_FFFF_FFFF_8000, 64'd3, 64'h0);
  endtask

  task automatic test_uncond_R6();
    run_word("R6", enc_long(24'h000100, 0, 1), 64'h3000, 64'd7, 64'h55,
             32'h0, 0, 1, 64'h3400, 64'd7, 64'h3004);
    run_word("R6", enc_long(24'hFFFFFF, 0, 0), 64'h3000, 64'd7, 64'h55,
             32'h0, 0, 1, 64'h2FFC, 64'd7, 64'h55);
    run_word("R6", enc_long(24'h000040, 1, 0), 64'h3000, 64'd0, 64'h55,
             32'h0, 0, 1, 64'h100, 64'd0, 64'h55);
  endtask

  task automatic test_indirect_R7();
    run_word("R7", enc_ind(5'b10100, 0, 1), 64'h100, 64'd9, 64'h5003,
             32'h0, 0, 1, 64'h5000, 64'd9, 64'h104);
    run_word("R7", enc_ind(5'b10100, 1, 0), 64'h100, 64'h7006, 64'h5003,
             32'h0, 0, 1, 64'h7004, 64'h7006, 64'h5003);
    run_word("R7", enc_ind(5'b10000, 1, 0), 64'h100, 64'h7006, 64'h5003,
             32'h0, 0, 1, 64'h7004, 64'h7005, 64'h5003);
  endtask

  task automatic test_link_R8_R9();
    run_word("R8", enc_cond(5'b01100, 5'd2, 14'h10, 0, 1), 64'h1000, 64'd5, 64'hAAAA,
             32'h0, 0, 0, 64'h1004, 64'd5, 64'h1004);
    run_word("R9", enc_cond(5'b00100, 5'd9, 14'h100, 0, 0), 64'h6000, 64'd5, 64'h1,
             32'h0040_0000, 0, 0, 64'h6004, 64'd5, 64'h1);
  endtask

  task automatic test_mode32_R10();
    run_word("R10", enc_long(24'h000001, 0, 1), 64'hFFFF_FFFC, 64'd1, 64'h0,
             32'h0, 1, 1, 64'h0, 64'd1, 64'h0);
    run_word("R10", enc_long(24'h000001, 0, 1), 64'hFFFF_FFFC, 64'd1, 64'h0,
             32'h0, 0, 1, 64'h1_0000_0000, 64'd1, 64'h1_0000_0000);
    run_word("R10", enc_cond(5'b10000, 5'd0, 14'h10, 0, 0), 64'h10, 64'h1_0000_0001, 64'h0,
             32'h0, 1, 1, 64'h50, 64'h1_0000_0000, 64'h0);
    run_word("R10", enc_ind(5'b10100, 0, 0), 64'h10, 64'd1, 64'hABCD_0000_1234,
             32'h0, 1, 1, 64'h1234, 64'd1, 64'hABCD_0000_1234);
  endtask

  task automatic test_nonbranch_R11();
    run_word("R11", {6'd31, 26'h3FF_FFFF}, 64'h400, 64'd9, 64'h77,
             32'hFFFF_FFFF, 0, 0, 64'h404, 64'd9, 64'h77);
    run_word("R11", {6'd19, 5'b10100, 5'd0, 5'd0, 10'd150, 1'b1}, 64'h400, 64'd9, 64'h77,
             32'h0, 0, 0, 64'h404, 64'd9, 64'h77);
  endtask

  task automatic test_idle_R2();
    run_word("R2", enc_long(24'h000010, 0, 0), 64'h900, 64'd4, 64'h8,
             32'h0, 0, 1, 64'h940, 64'd4, 64'h8);
    @(negedge clk);
    instr_i = enc_long(24'h000200, 0, 1); pc_i = 64'hF000; ctr_i = 64'd99;
    lr_i = 64'd98; valid_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R2", "valid_o idle", XLEN'(valid_o), '0);
    chk("R2", "next_pc_o held", next_pc_o, 64'h940);
    chk("R2", "ctr_o held", ctr_o, 64'd4);
    chk("R2", "lr_o held", lr_o, 64'h8);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; valid_i = 1'b0; instr_i = '0; pc_i = '0; ctr_i = '0; lr_i = '0;
    cr_i = '0; mode32_i = 1'b0;
    repeat (3) @(negedge clk);
    test_reset_R1();
    rst = 1'b0;
    @(negedge clk);
    test_reset_R1();
    test_cond_bit_R3();
    test_counter_R4();
    test_absolute_R5();
    test_uncond_R6();
    test_indirect_R7();
    test_link_R8_R9();
    test_mode32_R10();
    test_nonbranch_R11();
    test_idle_R2();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule